// File: doc/BRIEF.md
# Watchdog and Clock-Settling Timer

This block is an 8-bit up-counter that serves three roles. As a watchdog, it resets the chip when software stops reloading it. As an interval timer, it raises an interrupt each time it wraps. As an oscillator-settling timer, it keeps the processor clock stopped for a programmed time after a PLL frequency change or after leaving standby. A free-running prescaler divides the peripheral clock to make the count clock. A small register bus gives access to the counter and to one control/status register.

Software reloads the counter through a keyed write, so stray stores cannot kick the watchdog. For a frequency change, software loads the settling time and the external sequencer pulses the change request. The block then counts, pulses the clock-resume strobe on the wrap and parks at zero. A standby exit works the same way, except that counting goes on after the wrap. If standby is still enabled when the count next reaches the midpoint, the block raises a sticky standby-enter request.

Top module: `guard_timer`

## Requirements
- R1: A power-on reset (`rst_n` low) clears the counter and every control bit. Every output is low after reset.
- R2: A counter write (`bus_sel`=0) loads `bus_wdata[7:0]` only when `bus_wdata[15:8]` equals 0x5A. A counter write with any other upper byte leaves the counter unchanged.
- R3: Control bits [2:0] choose the count clock. Codes 0 to 7 divide the peripheral clock by 1, 4, 16, 32, 64, 256, 1024 and 4096, taken from a free-running prescaler.
- R4: In normal operation the counter advances only while control bit 5 (enable) is 1. With enable 0 there is no count, no reset and no interrupt.
- R5: Control bit 3 set to 1 selects watchdog mode. In this mode a wrap from 0xFF to 0x00 sets flag bit 6 and starts an 8-cycle reset pulse in the next cycle. The pulse goes on `rst_a_o` when bit 4 is 0 and on `rst_b_o` when bit 4 is 1. The counter keeps counting.
- R6: With bit 3 at 0 (interval mode), a wrap sets flag bit 7, and `irq_o` follows that flag. Writing the control register with bit 7 at 0 clears it, and writing bit 7 at 1 leaves it unchanged. Bit 6 behaves the same way.
- R7: A `freq_chg_i` pulse starts counting from the loaded value whatever the enable bit. On the wrap, `clk_resume_o` pulses for one cycle, no flag is set, and the counter holds 0x00 until the next keyed counter write.
- R8: A `stby_exit_i` pulse starts counting from the loaded value whatever the enable bit. On the wrap, `clk_resume_o` pulses for one cycle, no flag is set, and counting continues from 0x00.
- R9: After the wrap that follows a standby exit, the count reaching 0x80 while `stby_en_i` is 1 sets `stby_enter_o`. Only a power-on reset clears it.
- R10: `bus_rdata` shows the counter when `bus_sel`=0. When `bus_sel`=1 it shows the control register {bit7 interval flag, bit6 watchdog flag, bit5 enable, bit4 reset type, bit3 mode, bits2:0 clock select}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects the counter, 1 selects the control register |
| bus_wdata | input | 16 | Write data; upper byte is the key for counter writes |
| bus_rdata | output | 8 | Read data of the selected register |
| freq_chg_i | input | 1 | Frequency-change request pulse |
| stby_exit_i | input | 1 | Standby-exit pulse |
| stby_en_i | input | 1 | Standby is still requested |
| clk_resume_o | output | 1 | One-cycle strobe to restart the processor clock |
| rst_a_o | output | 1 | Reset pulse of the first kind |
| rst_b_o | output | 1 | Reset pulse of the second kind |
| irq_o | output | 1 | Interval interrupt, level |
| stby_enter_o | output | 1 | Sticky request to re-enter standby |

## Verification
A wrong phase shows within one count tick. A settle phase left too early stops the count at the wrong value, and one entered wrongly makes the counter move with enable clear. Both are visible on `bus_rdata` in the next cycle. A flag or pulse set on the wrong wrap shows on `irq_o`, on the reset pins or on `clk_resume_o` in the cycle after the wrap. A behavioural model compares all of these every clock.

// File: rtl/guard_pkg.sv
package guard_pkg;
    typedef enum logic [2:0] {
        PH_RUN  = 3'd0,
        PH_FREQ = 3'd1,
        PH_PARK = 3'd2,
        PH_STBY = 3'd3,
        PH_WAKE = 3'd4
    } phase_e;

    localparam int CB_IOVF  = 7;
    localparam int CB_WOVF  = 6;
    localparam int CB_EN    = 5;
    localparam int CB_RTYPE = 4;
    localparam int CB_MODE  = 3;

    function automatic int div_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 10;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler import guard_pkg::*; #(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cks,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q, mask;

    always_comb begin
        mask  = PRE_W'((1 << div_shift(cks)) - 1);
        tick  = &(pre_q | ~mask);
        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/gt_rst_pulse.sv
module gt_rst_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic kind,
    output logic rst_a,
    output logic rst_b
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] left;
        logic          kind;
    } pulse_t;

    pulse_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.left = CW'(LEN);
            d.kind = kind;
        end else if (q.left != '0) begin
            d.left = q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rst_a = (q.left != '0) && !q.kind;
    assign rst_b = (q.left != '0) &&  q.kind;
endmodule

// File: rtl/guard_timer.sv
module guard_timer import guard_pkg::*; #(
    parameter int         CNT_W   = 8,
    parameter int         KEY_W   = 8,
    parameter logic [7:0] WR_KEY  = 8'h5A,
    parameter int         PRE_W   = 12,
    parameter int         RST_LEN = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_sel,
    input  logic [CNT_W+KEY_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]       bus_rdata,
    input  logic                   freq_chg_i,
    input  logic                   stby_exit_i,
    input  logic                   stby_en_i,
    output logic                   clk_resume_o,
    output logic                   rst_a_o,
    output logic                   rst_b_o,
    output logic                   irq_o,
    output logic                   stby_enter_o
);
    localparam int          DW   = CNT_W + KEY_W;
    localparam [CNT_W-1:0]  HALF = CNT_W'(1) << (CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [2:0]       cks;
        logic             wd_mode;
        logic             rtype;
        logic             en;
        logic             wovf;
        logic             iovf;
        phase_e           ph;
        logic             resume;
        logic             sleep_req;
    } regs_t;

    regs_t q, d;
    logic  tick, counting, bump, wrap, key_ok, start_rst, en_now;

    gt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .cks(q.cks), .tick(tick)
    );

    gt_rst_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(start_rst), .kind(q.rtype),
        .rst_a(rst_a_o), .rst_b(rst_b_o)
    );

    always_comb begin
        d         = q;
        d.resume  = 1'b0;
        start_rst = 1'b0;
        counting  = (q.ph == PH_RUN) ? q.en : (q.ph != PH_PARK);
        bump      = counting && tick;
        wrap      = bump && (&q.cnt);
        key_ok    = bus_wr && !bus_sel && (bus_wdata[DW-1:CNT_W] == KEY_W'(WR_KEY));

        if (bump) d.cnt = q.cnt + 1'b1;

        // control write: flags can only be cleared by software
        if (bus_wr && bus_sel) begin
            d.cks     = bus_wdata[2:0];
            d.wd_mode = bus_wdata[CB_MODE];
            d.rtype   = bus_wdata[CB_RTYPE];
            d.en      = bus_wdata[CB_EN];
            d.wovf    = q.wovf & bus_wdata[CB_WOVF];
            d.iovf    = q.iovf & bus_wdata[CB_IOVF];
        end

        case (q.ph)
            PH_RUN: if (wrap) begin
                if (q.wd_mode) begin
                    d.wovf    = 1'b1;
                    start_rst = 1'b1;
                end else begin
                    d.iovf = 1'b1;
                end
            end
            PH_FREQ: if (wrap) begin
                d.resume = 1'b1;
                d.ph     = PH_PARK;
            end
            PH_STBY: if (wrap) begin
                d.resume = 1'b1;
                d.ph     = PH_WAKE;
            end
            PH_WAKE: if (bump && d.cnt == HALF) begin
                if (stby_en_i) d.sleep_req = 1'b1;
                d.ph = PH_RUN;
            end
            default: ;
        endcase

        if (key_ok) begin
            d.cnt = bus_wdata[CNT_W-1:0];
            if (d.ph == PH_PARK) d.ph = PH_RUN;
        end

        if (q.ph == PH_RUN || q.ph == PH_PARK) begin
            if (freq_chg_i)       d.ph = PH_FREQ;
            else if (stby_exit_i) d.ph = PH_STBY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_now       = q.en;
    assign clk_resume_o = q.resume;
    assign irq_o        = q.iovf;
    assign stby_enter_o = q.sleep_req;
    assign bus_rdata    = bus_sel ? {q.iovf, q.wovf, q.en, q.rtype, q.wd_mode, q.cks}
                                  : q.cnt;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_sel,
    input logic [DW-1:0] bus_wdata,
    input logic          en_now,
    input logic          irq_o,
    input logic          rst_a_o,
    input logic          rst_b_o,
    input logic          clk_resume_o,
    input logic          stby_enter_o
);
    // R5
    rst_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_a_o && rst_b_o));

    // R4
    rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_a_o || rst_b_o) |-> $past(en_now));

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(bus_wr && bus_sel && !bus_wdata[7]));

    // R7
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_resume_o |=> !clk_resume_o);

    // R9
    sleep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stby_enter_o |=> stby_enter_o);
endmodule

bind guard_timer guard_timer_chk #(.DW(CNT_W + KEY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .en_now(en_now), .irq_o(irq_o),
    .rst_a_o(rst_a_o), .rst_b_o(rst_b_o), .clk_resume_o(clk_resume_o),
    .stby_enter_o(stby_enter_o)
);

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_sel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        freq_chg_i = 1'b0, stby_exit_i = 1'b0, stby_en_i = 1'b0;
    logic        clk_resume_o, rst_a_o, rst_b_o, irq_o, stby_enter_o;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    guard_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .freq_chg_i(freq_chg_i), .stby_exit_i(stby_exit_i), .stby_en_i(stby_en_i),
        .clk_resume_o(clk_resume_o), .rst_a_o(rst_a_o), .rst_b_o(rst_b_o),
        .irq_o(irq_o), .stby_enter_o(stby_enter_o)
    );

    // behavioural reference: phases 0 run,1 settle-freq,2 parked,3 settle-stby,4 woken
    int m_pre, m_cnt, m_cks, m_ph, m_left;
    bit m_mode, m_rtype, m_en, m_wovf, m_iovf, m_res, m_sleep, m_kind;

    function automatic int ratio(int c);
        int r[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
        return r[c];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_cks = 0; m_ph = 0; m_left = 0;
            m_mode = 0; m_rtype = 0; m_en = 0; m_wovf = 0; m_iovf = 0;
            m_res = 0; m_sleep = 0; m_kind = 0;
        end else begin
            bit tk, run, ov, go; int nc, np, cur_ph; bit rt;
            tk = (m_pre % ratio(m_cks)) == ratio(m_cks) - 1;
            m_pre = (m_pre + 1) % 4096;
            cur_ph = m_ph; rt = m_rtype;
            run = (cur_ph == 0) ? m_en : (cur_ph != 2);
            nc = m_cnt; ov = 0; go = 0; np = cur_ph;
            if (run && tk) begin nc = (m_cnt + 1) % 256; ov = (m_cnt == 255); end
            if (bus_wr && bus_sel) begin
                m_cks = bus_wdata[2:0]; m_mode = bus_wdata[3]; m_rtype = bus_wdata[4];
                m_en = bus_wdata[5]; m_wovf = m_wovf && bus_wdata[6];
                m_iovf = m_iovf && bus_wdata[7];
            end
            m_res = 0;
            if (cur_ph == 0 && ov) begin
                if (m_mode_prev()) begin m_wovf = 1; go = 1; end else m_iovf = 1;
            end
            if (cur_ph == 1 && ov) begin m_res = 1; np = 2; end
            if (cur_ph == 3 && ov) begin m_res = 1; np = 4; end
            if (cur_ph == 4 && run && tk && nc == 128) begin
                if (stby_en_i) m_sleep = 1;
                np = 0;
            end
            if (bus_wr && !bus_sel && bus_wdata[15:8] == 8'h5A) begin
                nc = bus_wdata[7:0];
                if (np == 2) np = 0;
            end
            if (cur_ph == 0 || cur_ph == 2) begin
                if (freq_chg_i) np = 1; else if (stby_exit_i) np = 3;
            end
            if (go) begin m_left = 8; m_kind = rt; end
            else if (m_left > 0) m_left--;
            m_cnt = nc; m_ph = np;
        end
    end

    // mode bit as held before this edge's control write
    bit mode_hold;
    always @(posedge clk or negedge rst_n)
        if (!rst_n) mode_hold <= 0;
        else mode_hold <= (bus_wr && bus_sel) ? bus_wdata[3] : mode_hold;
    function automatic bit m_mode_prev(); return mode_hold; endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        chk("R10 rdata", bus_rdata, bus_sel ?
            {m_iovf, m_wovf, m_en, m_rtype, m_mode, m_cks[2:0]} : m_cnt[7:0]);
        chk("R5 rst_a", rst_a_o, (m_left > 0) && !m_kind);
        chk("R5 rst_b", rst_b_o, (m_left > 0) && m_kind);
        chk("R6 irq", irq_o, m_iovf);
        chk("R7 resume", clk_resume_o, m_res);
        chk("R9 stby_enter", stby_enter_o, m_sleep);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic wr(bit sel, logic [15:0] v);
        bus_sel = sel; bus_wdata = v; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask
    task automatic rd(bit sel, output int v);
        bus_sel = sel; #0.2; v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        step(3); rst_n = 1'b1; step(1);
        // R1
        rd(1, v); chk("R1 ctrl after reset", v, 0);
        rd(0, v); chk("R1 cnt after reset", v, 0);
        chk("R1 outputs", {rst_a_o, rst_b_o, irq_o, clk_resume_o, stby_enter_o}, 0);

        // R2
        wr(0, 16'h5A37); rd(0, v); chk("R2 keyed write", v, 8'h37);
        wr(0, 16'h1299); rd(0, v); chk("R2 bad key ignored", v, 8'h37);

        // R3: divide by 4
        wr(0, 16'h5A00); wr(1, 16'h0021); step(40);
        rd(0, v); chk("R3 div4 count in range", (v >= 9 && v <= 11), 1);
        wr(1, 16'h0000);

        // R4
        wr(0, 16'h5AFF); wr(1, 16'h0008); step(300);
        rd(0, v); chk("R4 no count when disabled", v, 8'hFF);
        chk("R4 no reset", rst_a_o | rst_b_o, 0);

        // R5: watchdog, second reset kind
        wr(0, 16'h5AFE); wr(1, 16'h0038); step(2);
        chk("R5 rst_b high", rst_b_o, 1); chk("R5 rst_a low", rst_a_o, 0);
        rd(1, v); chk("R5 wovf flag", v, 8'h78);
        rd(0, v); chk("R5 keeps counting", v, 8'h00);
        wr(1, 16'h0000); step(12);

        // R6
        wr(0, 16'h5AFF); wr(1, 16'h0020); step(1);
        chk("R6 irq set", irq_o, 1);
        wr(1, 16'h00A0); chk("R6 write 1 keeps", irq_o, 1);
        wr(1, 16'h0000); chk("R6 write 0 clears", irq_o, 0);

        // R7
        wr(0, 16'h5AF0); freq_chg_i = 1'b1; step(1); freq_chg_i = 1'b0;
        step(30); rd(0, v); chk("R7 parked at zero", v, 0);
        step(40); rd(0, v); chk("R7 still parked", v, 0);
        rd(1, v); chk("R7 no flag", v, 0);
        wr(0, 16'h5A05); rd(0, v); chk("R7 released by keyed write", v, 5);

        // R8
        wr(0, 16'h5AF8); stby_exit_i = 1'b1; step(1); stby_exit_i = 1'b0;
        step(30); rd(0, v); chk("R8 counts on past wrap", v, 8'h16);
        rd(1, v); chk("R8 no flag", v, 0);
        step(150); rd(0, v); chk("R8 stops at midpoint", v, 8'h80);
        chk("R9 no request with standby off", stby_enter_o, 0);

        // R9
        stby_en_i = 1'b1;
        wr(0, 16'h5AF8); stby_exit_i = 1'b1; step(1); stby_exit_i = 1'b0;
        step(145); chk("R9 request raised", stby_enter_o, 1);
        stby_en_i = 1'b0; wr(1, 16'h0000); wr(0, 16'h5A00);
        chk("R9 request sticky", stby_enter_o, 1);
        rst_n = 1'b0; step(1); rst_n = 1'b1; step(1);
        chk("R9 cleared by reset", stby_enter_o, 0);

        step(5);
        finish_run();
    end
endmodule